// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when a timer/counter advances. It holds a one-byte control register whose low four bits choose the source of a single-cycle count-enable pulse. The source can be nothing (timer stopped), the system clock itself, the clock divided by one of six fixed powers of two (2, 4, 8, 64, 256, 1024), or one of eight synchronous event strobes. The counter core sits beside this block and advances by one in every cycle in which `tick` is high.

Division comes from one free-running prescaler counter shared by all divided rates. A divided rate produces a pulse whenever the low bits of that counter are all ones. The prescaler is held at zero while the timer is stopped, so the first pulse after the timer starts arrives at a fixed and known delay. Changing from one divided rate to another does not restart the prescaler, so the phase of the running count carries across the change. A status output reports a select value that does not suit a high-resolution output stage when that stage is requested.

Top module: `tmr_src_sel`

## Requirements
- R1: `rd_data[3:0]` returns the stored select value and `rd_data[7:4]` always reads as zero. Bits 7:4 of a written byte are discarded.
- R2: With select 0000 (off), `tick` stays low and the prescaler stays at zero.
- R3: Selects 0001, 0010, 0011 and 0100 divide the clock by 1, 2, 4 and 8. When one of these is written while the timer is off, the first `tick` comes in the Nth cycle after the write edge, and a further `tick` follows every N cycles after that.
- R4: Selects 0101, 0110 and 0111 divide the clock by 64, 256 and 1024. The timing of the first `tick` and of the later ticks follows the same rule as in R3.
- R5: A select of the form 1nnn (bit 3 set) makes `tick` equal to `evt_in[nnn]` in the same cycle. There is no edge detection.
- R6: After reset the register reads 0x00, `tick` is low and `hires_err` is low.
- R7: `hires_err` is high exactly when `hires_req` is high and the stored select is not 0001.
- R8: A written select takes effect in the cycle after the write edge. A change between divided rates keeps the prescaler running, so `tick` in that cycle already follows the new rate applied to the running count.
- R9: A cycle in which `wr_en` is low leaves the register unchanged, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write; bits 3:0 are the select |
| rd_data | output | 8 | Readback of the control byte |
| evt_in | input | 8 | Synchronous single-cycle event strobes |
| hires_req | input | 1 | High-resolution output stage is requested |
| tick | output | 1 | Count-enable pulse to the counter core |
| hires_err | output | 1 | Select value does not suit the requested high-resolution stage |

## Verification
A wrong prescaler value stays hidden while the select is off or in event mode. It shows up as a misplaced `tick` only once a divided rate is active, and at the slowest rate this can take up to 1024 cycles. For that reason the bench measures the delay to the first tick after start-up at every rate, and also checks `tick` in every cycle against an independent cycle model. A wrong select register shows on `rd_data` in the very next cycle, and it also shows at once on `tick` and `hires_err`. The bench compares all three outputs in every cycle.

// File: rtl/tss_pkg.sv
// Shared constants and helpers for the timer tick source selector.
// Assumes select codes 1..7 map to the divided rates in ascending order.
package tss_pkg;
    localparam int SEL_W    = 4;
    localparam int DATA_W   = 8;
    localparam int CNT_W    = 10;
    localparam int NUM_TAPS = 7;
    localparam int EVT_N    = 8;

    // Log2 of the division ratio for a divided select code (1..7).
    function automatic int tap_shift(input int code);
        case (code)
            1:       return 0;
            2:       return 1;
            3:       return 2;
            4:       return 3;
            5:       return 6;
            6:       return 8;
            7:       return 10;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/tss_ctrl_reg.sv
// Control register holding the tick source select.
// Only the select bits are stored. Reserved bits read as zero.
// Assumes that a write and the reset never need to be merged in one cycle.
module tss_ctrl_reg #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] rd_data
);
    // Store the select on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wr_sel;
    end

    // Readback with the reserved field forced to zero.
    always_comb begin
        rd_data              = '0;
        rd_data[SEL_W-1:0]   = sel_q;
    end
endmodule

// File: rtl/tss_prescaler.sv
// Free-running prescaler with one single-cycle pulse per divided rate.
// The counter is held at zero while run is low. Tap g serves select code g+1.
// Assumes every tap shift fits within CNT_W bits.
module tss_prescaler #(
    parameter int CNT_W    = 10,
    parameter int NUM_TAPS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    output logic [NUM_TAPS-1:0] tap_tick
);
    logic [CNT_W-1:0] cnt_q;

    // Count freely while running; hold at zero when stopped or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // One pulse per tap whenever the low shift bits of the count are all ones.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int SH = tss_pkg::tap_shift(g + 1);
        if (SH == 0) begin : g_full
            assign tap_tick[g] = run;
        end else begin : g_div
            assign tap_tick[g] = run && (&cnt_q[SH-1:0]);
        end
    end
endmodule

// File: rtl/tss_evt_mux.sv
// Picks one of the synchronous event strobes and passes it straight through.
// Assumes each strobe is already synchronous and one cycle wide.
module tss_evt_mux #(
    parameter int EVT_N = 8,
    parameter int IDX_W = $clog2(EVT_N)
) (
    input  logic [EVT_N-1:0] evt_in,
    input  logic [IDX_W-1:0] idx,
    output logic             evt_tick
);
    // Direct selection, with no edge detection.
    always_comb begin
        evt_tick = evt_in[idx];
    end
endmodule

// File: rtl/tmr_src_sel.sv
// Top level of the timer tick source selector.
// Select 0 stops the timer. Codes 1..7 choose a divided rate.
// Codes with the top bit set choose an event strobe.
// Assumes EVT_N equals 2**(SEL_W-1) so that every event code is reachable.
module tmr_src_sel #(
    parameter int SEL_W    = tss_pkg::SEL_W,
    parameter int DATA_W   = tss_pkg::DATA_W,
    parameter int CNT_W    = tss_pkg::CNT_W,
    parameter int NUM_TAPS = tss_pkg::NUM_TAPS,
    parameter int EVT_N    = tss_pkg::EVT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic              hires_req,
    output logic              tick,
    output logic              hires_err
);
    localparam int IDX_W = SEL_W - 1;
    localparam logic [SEL_W-1:0] SEL_FULL = SEL_W'(1);

    logic [SEL_W-1:0]    sel_q;
    logic [NUM_TAPS-1:0] tap_tick;
    logic                evt_tick;
    logic                run;
    logic                is_evt;
    logic [IDX_W-1:0]    src_idx;
    logic                unused_rsvd;

    assign unused_rsvd = ^wr_data[DATA_W-1:SEL_W];

    tss_ctrl_reg #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_data[SEL_W-1:0]),
        .sel_q   (sel_q),
        .rd_data (rd_data)
    );

    // Decode the stored select into its run, mode and index parts.
    always_comb begin
        run     = (sel_q != '0);
        is_evt  = sel_q[SEL_W-1];
        src_idx = sel_q[IDX_W-1:0];
    end

    tss_prescaler #(.CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tap_tick (tap_tick)
    );

    tss_evt_mux #(.EVT_N(EVT_N), .IDX_W(IDX_W)) u_evt (
        .evt_in   (evt_in),
        .idx      (src_idx),
        .evt_tick (evt_tick)
    );

    // Route the chosen source to the single tick output.
    always_comb begin
        tick = 1'b0;
        if (is_evt)
            tick = evt_tick;
        else if (src_idx != '0)
            tick = tap_tick[src_idx - 1'b1];
    end

    // Flag a select that does not suit the high-resolution stage.
    always_comb begin
        hires_err = hires_req && (sel_q != SEL_FULL);
    end
endmodule

// File: rtl/tss_chk.sv
// Assertion checker for tmr_src_sel, attached with bind below.
// Assumes the default byte layout: select in bits 3:0 and eight event strobes.
module tss_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] evt_in,
    input logic       hires_req,
    input logic       tick,
    input logic       hires_err
);
    // R1: the reserved field never reads as one.
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:4] == 4'h0);

    // R2: a stopped timer gives no tick.
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3:0] == 4'h0) |-> !tick);

    // R3: the undivided rate ticks in every cycle.
    p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3:0] == 4'h1) |-> tick);

    // R3: at divide-by-2, two ticks never come in consecutive cycles.
    p_half_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3:0] == 4'h2 && tick) |=> !(rd_data[3:0] == 4'h2 && tick));

    // R5: in event mode the tick follows the chosen strobe.
    p_evt_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |-> (tick == evt_in[rd_data[2:0]]));

    // R7: the undivided select never raises the error flag.
    p_hires_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3:0] == 4'h1) |-> !hires_err);

    // R7: a non-undivided select with a request always raises the flag.
    p_hires_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hires_req && rd_data[3:0] != 4'h1) |-> hires_err);

    // R8: a write shows on the readback in the next cycle.
    p_wr_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[3:0] == $past(wr_data[3:0])));

    // R9: the select stays put without a write.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

bind tmr_src_sel tss_chk u_tss_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .evt_in    (evt_in),
    .hires_req (hires_req),
    .tick      (tick),
    .hires_err (hires_err)
);

// File: tb/tb_tmr_src_sel.sv
`timescale 1ns/1ps
module tb_tmr_src_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] evt_in = 8'h00;
    logic       hires_req = 1'b0;
    logic       tick;
    logic       hires_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // Bench model state: stored select and prescaler count.
    logic [3:0] m_sel = 4'h0;
    int         m_cnt = 0;
    bit         m_wrote = 1'b0;

    always #2.5 clk = ~clk;

    tmr_src_sel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .evt_in(evt_in), .hires_req(hires_req),
        .tick(tick), .hires_err(hires_err)
    );

    function automatic int ratio_log2(input logic [3:0] s);
        case (s)
            4'h1: return 0;
            4'h2: return 1;
            4'h3: return 2;
            4'h4: return 3;
            4'h5: return 6;
            4'h6: return 8;
            4'h7: return 10;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_tick(input logic [3:0] s, input int cnt, input logic [7:0] ev);
        int mask;
        if (s == 4'h0) return 1'b0;
        if (s[3]) return ev[s[2:0]];
        mask = (1 << ratio_log2(s)) - 1;
        return (cnt & mask) == mask;
    endfunction

    function automatic string tick_req(input logic [3:0] s, input bit wrote);
        if (wrote) return "R8";
        if (s == 4'h0) return "R2";
        if (s[3]) return "R5";
        if (s >= 4'h5) return "R4";
        return "R3";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model the register and the prescaler from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel   <= 4'h0;
            m_cnt   <= 0;
            m_wrote <= 1'b0;
        end else begin
            m_cnt   <= (m_sel == 4'h0) ? 0 : ((m_cnt + 1) % 1024);
            m_wrote <= wr_en;
            if (wr_en) m_sel <= wr_data[3:0];
        end
    end

    // Compare every output against the model in the middle of each cycle.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(tick == exp_tick(m_sel, m_cnt, evt_in), tick_req(m_sel, m_wrote),
                  tick, exp_tick(m_sel, m_cnt, evt_in));
            check(rd_data == {4'h0, m_sel}, m_wrote ? "R1" : "R9", rd_data, {4'h0, m_sel});
            check(hires_err == (hires_req && m_sel != 4'h1), "R7",
                  hires_err, hires_req && m_sel != 4'h1);
        end
    end

    task automatic write_sel(input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = $urandom;
    endtask

    // Measure the delay from the start-up write to the first tick.
    task automatic first_tick(input logic [3:0] s, input int n, input string req);
        int k;
        write_sel(8'h00);
        repeat (3) @(posedge clk);
        write_sel({4'h0, s});
        k = 1;
        @(negedge clk);
        while (!tick && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check(k == n, req, k, n);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: reset state seen at the ports.
        check(rd_data == 8'h00, "R6", rd_data, 0);
        check(tick == 1'b0, "R6", tick, 0);
        check(hires_err == 1'b0, "R6", hires_err, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: reserved write bits are dropped on readback.
        write_sel(8'hF3);
        @(negedge clk);
        check(rd_data == 8'h03, "R1", rd_data, 8'h03);

        // R9: data presented without a strobe changes nothing.
        @(posedge clk); #1;
        wr_data = 8'h07;
        @(negedge clk);
        check(rd_data == 8'h03, "R9", rd_data, 8'h03);

        // R3 and R4: start-up delay at every divided rate.
        first_tick(4'h1, 1, "R3");
        first_tick(4'h2, 2, "R3");
        first_tick(4'h3, 4, "R3");
        first_tick(4'h4, 8, "R3");
        first_tick(4'h5, 64, "R4");
        first_tick(4'h6, 256, "R4");
        first_tick(4'h7, 1024, "R4");

        // R8: change rate while running; the model checks the phase carry-over.
        write_sel(8'h02);
        repeat (5) @(posedge clk);
        write_sel(8'h04);
        repeat (20) @(posedge clk);
        write_sel(8'h03);
        repeat (10) @(posedge clk);

        // R5: event strobes on the selected channel pass straight through.
        write_sel(8'h0D);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            evt_in = $urandom;
        end

        // Random mix of writes, events and high-resolution requests.
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk); #1;
            evt_in    = $urandom;
            hires_req = ($urandom % 4) == 0;
            if (($urandom % 60) == 0) begin
                wr_en   = 1'b1;
                wr_data = (($urandom % 3) == 0) ? 8'h01 : 8'($urandom);
            end else begin
                wr_en   = 1'b0;
                wr_data = $urandom;
            end
        end
        @(posedge clk); #1;
        wr_en = 1'b0;

        // R2: back to off, so ticks stop and the prescaler restarts from zero.
        write_sel(8'h00);
        repeat (30) @(posedge clk);
        first_tick(4'h3, 4, "R2");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule